// File: doc/BRIEF.md
# I/O Request Descriptor Router

This block decides where an I/O read or write request is sent. Each incoming request carries a 32-bit address, a read/write direction and a special-cycle flag. The block compares it in parallel against a bank of masked-range descriptors and a bank of hole-punch descriptors. The winning descriptor supplies a 3-bit destination port ID. A request that no descriptor claims goes to a fixed subtractive port. The address leaves the block exactly as it came in, because no translation is performed.

Descriptors are 64-bit words loaded through a simple index/data configuration port. Masked-range descriptors occupy indices 0 to N_MASK-1, and hole-punch descriptors follow them. A masked-range descriptor treats the special-cycle flag as one more address bit. This lets shutdown, halt and processor-specific special cycles, which are flagged writes to low addresses, be steered separately from ordinary I/O. A hole-punch descriptor splits a 256 KiB window into sixteen 16 KiB chunks. Each chunk has its own read enable and write enable, so the descriptor can claim parts of a window per direction and leave holes.

The routed result is registered. It is held under a valid/ready handshake, and the input stalls while a result waits.

Top module: `io_desc_router`

## Requirements
- R1: A masked-range descriptor (fields: destination [63:61], flag [60], base [39:20], mask [19:0]) matches when request address bits [31:12] ANDed with mask equal base. A descriptor whose mask is all zero never matches.
- R2: A masked-range descriptor matches only when the request's special-cycle flag equals its bit 60. On a match, the result takes the destination from bits [63:61].
- R3: A hole-punch descriptor (fields: destination [63:61], write enables [47:32], read enables [31:16], base [13:0]) matches a request that meets all of the following: the special-cycle flag is clear, address bits [31:18] equal base, and the enable bit selected by address bits [17:14] is set in the field for the request's direction.
- R4: A request that matches no descriptor is routed to port SUB_ID (default 7).
- R5: When several descriptors match, the lowest index wins, where masked-range descriptors come before hole-punch descriptors. Any accepted request with more than one match sets `multi_hit`, which stays set until reset.
- R6: `out_addr` equals the accepted request's address bit for bit.
- R7: A result appears on the outputs one cycle after the request is accepted (`req_valid && req_ready` at a rising edge). It holds stable while `out_ready` is low, and `req_ready` is low during such a stall.
- R8: After reset, `out_valid` and `multi_hit` are 0. Descriptor 0 routes flagged requests with addresses 0 to FFFFh to port SPEC_ID (default 1). Every other descriptor is inert.
- R9: A configuration write to index N_MASK+N_HOLE or above changes no descriptor. A write to a valid index affects requests accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | $clog2(N_MASK+N_HOLE) | Descriptor index |
| cfg_data | input | 64 | Descriptor word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Request I/O address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spec | input | 1 | Special-cycle flag |
| out_valid | output | 1 | Routed result present |
| out_ready | input | 1 | Downstream takes the result |
| out_dest | output | 3 | Destination port ID |
| out_addr | output | 32 | Untranslated request address |
| multi_hit | output | 1 | Sticky flag: some request matched more than one descriptor |

## Verification
The bench sends flagged writes at addresses 0, 1, FFFFh and 10000h, plus an unflagged write to 0. These separate the reset default and the extra flag bit from a plain address range. Exact-mask and partial-mask descriptors are probed just inside and just outside their ranges, and a zero-mask descriptor is probed as well. Hole-punch windows are probed with reads and writes on an enabled chunk, a disabled chunk and an adjacent window, and with a flagged write. Deliberately overlapping descriptors and out-of-range configuration writes expose the priority order and the index decoding. A stalled result with a second request waiting checks the hold behaviour.

// File: rtl/io_route_pkg.sv
`timescale 1ns/1ps
package io_route_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DESC_W = 64;
  localparam int unsigned DEST_W = 3;

  typedef logic [DEST_W-1:0] dest_t;

  // masked-range descriptor, reserved bits dropped
  typedef struct packed {
    dest_t       dest;
    logic        spec;
    logic [19:0] base;
    logic [19:0] mask;
  } mdesc_t;

  // hole-punch descriptor, reserved bits dropped
  typedef struct packed {
    dest_t       dest;
    logic [15:0] wen;
    logic [15:0] ren;
    logic [13:0] base;
  } hdesc_t;

  // reset image: flagged cycles at 0..FFFFh go to the given port
  function automatic mdesc_t spec_default(input dest_t id);
    mdesc_t d;
    d.dest = id;
    d.spec = 1'b1;
    d.base = 20'h00000;
    d.mask = 20'hFFFF0;
    return d;
  endfunction
endpackage

// File: rtl/io_mask_bank.sv
`timescale 1ns/1ps
module io_mask_bank
  import io_route_pkg::*;
#(
  parameter int unsigned N_DESC  = 4,
  parameter dest_t       SPEC_ID = 3'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_DESC-1:0]    wr_sel,
  input  logic [DESC_W-1:0]    wr_data,
  input  logic [19:0]          addr_hi,   // request address [31:12]
  input  logic                 req_spec,
  output logic [N_DESC-1:0]    hit,
  output dest_t [N_DESC-1:0]   dest
);
  mdesc_t wr_fields;
  logic   unused_rsvd;

  assign wr_fields.dest = wr_data[63:61];
  assign wr_fields.spec = wr_data[60];
  assign wr_fields.base = wr_data[39:20];
  assign wr_fields.mask = wr_data[19:0];
  assign unused_rsvd    = ^wr_data[59:40];

  for (genvar i = 0; i < N_DESC; i++) begin : g_slot
    localparam mdesc_t RST_VAL = (i == 0) ? spec_default(SPEC_ID) : '0;
    mdesc_t slot_q, slot_d;

    always_comb begin
      slot_d = slot_q;
      if (wr_sel[i]) slot_d = wr_fields;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= RST_VAL;
      else        slot_q <= slot_d;
    end

    assign hit[i]  = (slot_q.mask != '0) &&
                     ((addr_hi & slot_q.mask) == slot_q.base) &&
                     (req_spec == slot_q.spec);
    assign dest[i] = slot_q.dest;
  end
endmodule

// File: rtl/io_hole_bank.sv
`timescale 1ns/1ps
module io_hole_bank
  import io_route_pkg::*;
#(
  parameter int unsigned N_DESC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_DESC-1:0]    wr_sel,
  input  logic [DESC_W-1:0]    wr_data,
  input  logic [17:0]          addr_hi,   // request address [31:14]
  input  logic                 req_write,
  input  logic                 req_spec,
  output logic [N_DESC-1:0]    hit,
  output dest_t [N_DESC-1:0]   dest
);
  hdesc_t     wr_fields;
  logic       unused_rsvd;
  logic [3:0] chunk;

  assign wr_fields.dest = wr_data[63:61];
  assign wr_fields.wen  = wr_data[47:32];
  assign wr_fields.ren  = wr_data[31:16];
  assign wr_fields.base = wr_data[13:0];
  assign unused_rsvd    = ^{wr_data[60:48], wr_data[15:14]};
  assign chunk          = addr_hi[3:0];

  for (genvar i = 0; i < N_DESC; i++) begin : g_slot
    hdesc_t slot_q, slot_d;
    logic   dir_en;

    always_comb begin
      slot_d = slot_q;
      if (wr_sel[i]) slot_d = wr_fields;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign dir_en  = req_write ? slot_q.wen[chunk] : slot_q.ren[chunk];
    assign hit[i]  = !req_spec && (addr_hi[17:4] == slot_q.base) && dir_en;
    assign dest[i] = slot_q.dest;
  end
endmodule

// File: rtl/io_hit_pick.sv
`timescale 1ns/1ps
module io_hit_pick
  import io_route_pkg::*;
#(
  parameter int unsigned N_IN   = 6,
  parameter dest_t       SUB_ID = 3'd7
) (
  input  logic [N_IN-1:0]   hit,
  input  dest_t [N_IN-1:0]  dest_in,
  output dest_t             dest_out,
  output logic              multi
);
  // walk from the top index down so the lowest matching index wins
  always_comb begin
    dest_out = SUB_ID;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (hit[i]) dest_out = dest_in[i];
    end
  end

  assign multi = (hit & (hit - 1'b1)) != '0;
endmodule

// File: rtl/io_desc_router.sv
`timescale 1ns/1ps
module io_desc_router
  import io_route_pkg::*;
#(
  parameter int unsigned N_MASK  = 4,
  parameter int unsigned N_HOLE  = 2,
  parameter logic [2:0]  SUB_ID  = 3'd7,
  parameter logic [2:0]  SPEC_ID = 3'd1,
  localparam int unsigned N_ALL  = N_MASK + N_HOLE,
  localparam int unsigned IDX_W  = (N_ALL > 1) ? $clog2(N_ALL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [63:0]       cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic              req_spec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_dest,
  output logic [31:0]       out_addr,
  output logic              multi_hit
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // configuration index decode; indices past N_ALL select nothing
  logic [N_ALL-1:0] wr_sel;
  always_comb begin
    for (int i = 0; i < N_ALL; i++) begin
      wr_sel[i] = cfg_we && (cfg_idx == IDX_W'(i));
    end
  end

  logic [N_MASK-1:0]  mask_hit;
  dest_t [N_MASK-1:0] mask_dest;
  logic [N_HOLE-1:0]  hole_hit;
  dest_t [N_HOLE-1:0] hole_dest;

  io_mask_bank #(.N_DESC(N_MASK), .SPEC_ID(SPEC_ID)) u_mask (
    .clk      (clk),
    .rst_n    (rst_ok),
    .wr_sel   (wr_sel[N_MASK-1:0]),
    .wr_data  (cfg_data),
    .addr_hi  (req_addr[31:12]),
    .req_spec (req_spec),
    .hit      (mask_hit),
    .dest     (mask_dest)
  );

  io_hole_bank #(.N_DESC(N_HOLE)) u_hole (
    .clk       (clk),
    .rst_n     (rst_ok),
    .wr_sel    (wr_sel[N_ALL-1:N_MASK]),
    .wr_data   (cfg_data),
    .addr_hi   (req_addr[31:14]),
    .req_write (req_write),
    .req_spec  (req_spec),
    .hit       (hole_hit),
    .dest      (hole_dest)
  );

  logic [N_ALL-1:0]  all_hit;
  dest_t [N_ALL-1:0] all_dest;
  dest_t             pick_dest;
  logic              pick_multi;

  assign all_hit  = {hole_hit, mask_hit};
  assign all_dest = {hole_dest, mask_dest};

  io_hit_pick #(.N_IN(N_ALL), .SUB_ID(SUB_ID)) u_pick (
    .hit      (all_hit),
    .dest_in  (all_dest),
    .dest_out (pick_dest),
    .multi    (pick_multi)
  );

  // output stage
  logic  fire;
  logic  ov_q, ov_d;
  logic  mh_q, mh_d;
  dest_t dest_q;
  logic [31:0] addr_q;

  assign req_ready = rst_ok && (!ov_q || out_ready);
  assign fire      = req_valid && req_ready;

  always_comb begin
    ov_d = ov_q;
    if (fire)           ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
    mh_d = mh_q | (fire & pick_multi);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ov_q <= 1'b0;
      mh_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      mh_q <= mh_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      dest_q <= pick_dest;
      addr_q <= req_addr;
    end
  end

  assign out_valid = ov_q;
  assign out_dest  = dest_q;
  assign out_addr  = addr_q;
  assign multi_hit = mh_q;
endmodule

// File: rtl/io_desc_router_chk.sv
`timescale 1ns/1ps
module io_desc_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_dest,
  input logic [31:0] out_addr,
  input logic        multi_hit
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_addr)));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);

  assert_addr_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_addr == $past(req_addr)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |=> multi_hit);
endmodule

bind io_desc_router io_desc_router_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dest  (out_dest),
  .out_addr  (out_addr),
  .multi_hit (multi_hit)
);

// File: tb/sim_io_desc_router.sv
`timescale 1ns/1ps
module sim_io_desc_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [63:0] cfg_data;
  logic        req_valid, req_ready, req_write, req_spec;
  logic [31:0] req_addr;
  logic        out_valid, out_ready, multi_hit;
  logic [2:0]  out_dest;
  logic [31:0] out_addr;

  always #2.5 clk = ~clk;

  io_desc_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_spec(req_spec), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_addr(out_addr), .multi_hit(multi_hit)
  );

  typedef struct {
    logic [31:0] addr;
    logic [2:0]  dest;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t got;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_mask(input logic [2:0] d, input logic s,
                                          input logic [19:0] b, input logic [19:0] m);
    return {d, s, 20'h0, b, m};
  endfunction

  function automatic logic [63:0] mk_hole(input logic [2:0] d, input logic [15:0] we,
                                          input logic [15:0] re, input logic [13:0] b);
    return {d, 13'h0, we, re, 2'b00, b};
  endfunction

  // inputs change 1 ns after the rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [2:0] idx, input logic [63:0] data);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = data;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input bit w, input bit s,
                      input logic [2:0] d, input string tag);
    q.push_back('{addr: a, dest: d, tag: tag});
    req_addr = a; req_write = w; req_spec = s; req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 100) begin
      tick();
      n++;
    end
    if (q.size() != 0) chk(1'b0, "R7", "results outstanding", q.size(), 0);
  endtask

  // monitor: a transfer happens at the edge after a cycle with valid and ready
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected result", out_addr, 0);
      end else begin
        got = q.pop_front();
        chk(out_dest == got.dest, got.tag, "dest", out_dest, got.dest);
        chk(out_addr == got.addr, "R6", "addr", out_addr, got.addr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_spec = 1'b0;
    out_ready = 1'b1;
    repeat (3) tick();
    chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    chk(multi_hit == 1'b0, "R8", "multi_hit in reset", multi_hit, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(req_ready == 1'b1, "R7", "ready after reset", req_ready, 1);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);

    // reset default: flagged writes 0..FFFFh go to port 1
    send(32'h0000_0000, 1, 1, 3'd1, "R8");
    send(32'h0000_0001, 1, 1, 3'd1, "R8");
    send(32'h0000_FFFF, 1, 1, 3'd1, "R8");
    send(32'h0001_0000, 1, 1, 3'd7, "R4");
    send(32'h0000_0000, 1, 0, 3'd7, "R2");
    drain();

    // exact and partial masks
    cfg(3'd1, mk_mask(3'd2, 1'b0, 20'h00010, 20'hFFFFF));
    cfg(3'd2, mk_mask(3'd3, 1'b0, 20'h00200, 20'hFFF00));
    send(32'h0001_0ABC, 0, 0, 3'd2, "R1");
    send(32'h0001_1000, 1, 0, 3'd7, "R4");
    send(32'h0001_0ABC, 1, 1, 3'd7, "R2");
    send(32'h0023_4567, 0, 0, 3'd3, "R1");
    send(32'h0033_4567, 0, 0, 3'd7, "R1");
    drain();

    // hole punching: window 40000h..7FFFFh, write chunk 5, read chunk 9
    cfg(3'd4, mk_hole(3'd4, 16'h0020, 16'h0200, 14'h0001));
    send(32'h0005_4000, 1, 0, 3'd4, "R3");
    send(32'h0005_4000, 0, 0, 3'd7, "R3");
    send(32'h0006_4000, 0, 0, 3'd4, "R3");
    send(32'h0006_4000, 1, 0, 3'd7, "R3");
    send(32'h0005_8000, 1, 0, 3'd7, "R3");
    send(32'h0009_4000, 1, 0, 3'd7, "R3");
    send(32'h0005_4000, 1, 1, 3'd7, "R3");
    drain();
    chk(multi_hit == 1'b0, "R5", "multi_hit before overlap", multi_hit, 0);

    // overlaps: lowest index wins
    cfg(3'd5, mk_hole(3'd5, 16'h0020, 16'h0000, 14'h0001));
    send(32'h0005_4000, 1, 0, 3'd4, "R5");
    drain();
    chk(multi_hit == 1'b1, "R5", "multi_hit after overlap", multi_hit, 1);
    cfg(3'd3, mk_mask(3'd6, 1'b0, 20'h00054, 20'hFFFFF));
    send(32'h0005_4000, 1, 0, 3'd6, "R5");
    send(32'h0006_4000, 0, 0, 3'd4, "R5");
    drain();

    // zero mask disables a descriptor
    cfg(3'd1, mk_mask(3'd2, 1'b0, 20'h00000, 20'h00000));
    send(32'h0001_0ABC, 0, 0, 3'd7, "R1");
    send(32'h0000_0000, 0, 0, 3'd7, "R1");
    drain();

    // out-of-range configuration indices
    cfg(3'd6, mk_hole(3'd5, 16'hFFFF, 16'hFFFF, 14'h0000));
    cfg(3'd7, mk_mask(3'd5, 1'b0, 20'h00000, 20'hFFFFF));
    send(32'h0000_4000, 0, 0, 3'd7, "R9");
    send(32'h0005_4000, 1, 0, 3'd6, "R9");
    send(32'h0000_0002, 1, 1, 3'd1, "R9");
    drain();
    chk(multi_hit == 1'b1, "R5", "multi_hit still set", multi_hit, 1);

    // back-pressure with a second request waiting
    out_ready = 1'b0;
    send(32'h0000_0002, 1, 1, 3'd1, "R7");
    chk(out_valid == 1'b1, "R7", "valid one cycle after accept", out_valid, 1);
    chk(req_ready == 1'b0, "R7", "ready low while stalled", req_ready, 0);
    q.push_back('{addr: 32'h0023_0000, dest: 3'd3, tag: "R7"});
    req_addr = 32'h0023_0000; req_write = 1'b0; req_spec = 1'b0; req_valid = 1'b1;
    repeat (3) tick();
    chk(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
    chk(out_dest == 3'd1, "R7", "dest held", out_dest, 1);
    chk(out_addr == 32'h0000_0002, "R7", "addr held", out_addr, 32'h2);
    out_ready = 1'b1;
    tick();
    req_valid = 1'b0;
    drain();
    tick();
    chk(out_valid == 1'b0, "R7", "valid drops after transfer", out_valid, 0);
    chk(q.size() == 0, "R7", "queue empty", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule